// File: doc/BRIEF.md
# Flash program/erase command controller

This block sequences page erase, word program and info-word read operations on an on-chip flash array made of two main banks and one small info area. The array inside the block is a behavioural model. Each page holds 2048 bytes, which is 512 words. A full bank has 128 pages, 256 KB in all. The default parameters model fewer pages per bank so that the array stays small. Software works through a small word-addressed register port. It fills a write buffer of up to 32 words. It then sets a transaction register with three fields: a word offset, a main/info select and a zero-based word count. To launch an operation it writes an unlock key and then an operation code to the control register of the chosen bank.

The controller validates each launch. It refuses a program whose words would run past a 256-byte (64-word) row, an unknown code, and a code sent to a bank that is already busy. While the operation runs, the bank's control register reads back the running code. Plain array reads to that bank are held off through a ready signal until the busy window closes. The effect on the array is applied at the close of that window. Errors collect in a register that empties itself when it is read.

Register map (word addresses on `reg_addr`):
- 0: key
- 1: bank 0 control
- 2: bank 1 control
- 3: transaction
- 4: error
- 5: info data out
- 32 to 63: write buffer words 0 to 31

Operation codes:
- 0x31415927: page erase
- 0x27182818: program
- 0x16021765: info read

The key value is 0xB11924E1.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset, both control registers and the error register read 0. `rd_ready` is 1, and every array word reads 0xFFFFFFFF.
- R2: An operation starts only when a write to a control register follows a key write of 0xB11924E1. A control write consumes the key, so a second code without a fresh key does not start.
- R3: A code written without a valid key is ignored and raises no error. This includes a code after a key write of any other value.
- R4: Once accepted, the control register reads the running code for exactly T cycles (T_PROG, T_ERASE or T_READ), starting the cycle after the control write. It reads 0 from the next cycle on.
- R5: Program (code 0x27182818, main select) is driven by the transaction register. Its bits [15:0] give the word offset, bit 16 gives info select and bits [21:17] give the count N. It updates words offset..offset+N to old AND buffer[i] and leaves word offset+N+1 untouched.
- R6: A program whose words cross a 64-word row is refused. The refusal sets error bit 0, starts nothing and changes no word. A range that ends exactly on the last word of a row is accepted.
- R7: Page erase (0x31415927) sets every word of the page holding the offset to 0xFFFFFFFF. Other pages are not affected.
- R8: Info read (0x16021765, info select) places the info word at the offset in the data-out register. Program with info select ANDs into the info area.
- R9: While a bank is busy, `rd_ready` is 0 for reads of that bank. Reads of the other bank proceed with `rd_ready` 1 and current data.
- R10: A control write to a busy bank is ignored. It sets error bit 1, and the running operation keeps its code and its completion cycle.
- R11: Reading the error register returns the pending bits and clears them the next cycle. Bits from separate events accumulate until read.
- R12: After a valid key, an unknown code, an erase with info select or an info read without info select sets error bit 2 and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears error register when it addresses it) |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from current state |
| rd_req | input | 1 | Array read request |
| rd_bank | input | 1 | Bank of the array read |
| rd_addr | input | 10 | Word index inside the bank for the array read |
| rd_ready | output | 1 | Low while the addressed bank is busy |
| rd_data | output | 32 | Array word at `rd_bank`/`rd_addr` |

## Verification
Register and array reads are combinational, so each read result is due in the same cycle as its strobe. The scoreboard monitor samples it at the falling edge of that cycle. A control write taken at a rising edge makes the control register read the running code in the next T cycles and 0 in cycle T+1. The bench polls exactly those cycles, or idles exactly T cycles before it checks the array, so an off-by-one in the busy window shows up as a mismatch. A refusal sets its error bit at the edge that takes the control write, so the bench reads the error register in the very next cycle. It then reads the register again in the cycle after that to expect zero.

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl #(
  parameter int PAGES      = 2,
  parameter int PAGE_BYTES = 2048,
  parameter int ROW_BYTES  = 256,
  parameter int BUF_WORDS  = 32,
  parameter int INFO_WORDS = 128,
  parameter int OFF_W      = 16,
  parameter int T_ERASE    = 20,
  parameter int T_PROG     = 6,
  parameter int T_READ     = 3
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      reg_wr,
  input  logic                                      reg_rd,
  input  logic [$clog2(BUF_WORDS):0]                reg_addr,
  input  logic [31:0]                               reg_wdata,
  output logic [31:0]                               reg_rdata,
  input  logic                                      rd_req,
  input  logic                                      rd_bank,
  input  logic [$clog2(PAGES*PAGE_BYTES/4)-1:0]     rd_addr,
  output logic                                      rd_ready,
  output logic [31:0]                               rd_data
);
  localparam int PAGE_W = PAGE_BYTES / 4;
  localparam int ROW_W  = ROW_BYTES / 4;
  localparam int BANK_W = PAGES * PAGE_W;
  localparam int AW     = $clog2(BANK_W);
  localparam int PLOG   = $clog2(PAGE_W);
  localparam int RL     = $clog2(ROW_W);
  localparam int IW     = $clog2(INFO_WORDS);
  localparam int SZW    = $clog2(BUF_WORDS);
  localparam int RA_W   = SZW + 1;
  localparam int TMAX   = (T_ERASE > T_PROG) ? ((T_ERASE > T_READ) ? T_ERASE : T_READ)
                                             : ((T_PROG > T_READ) ? T_PROG : T_READ);
  localparam int CNT_W  = $clog2(TMAX + 1);

  localparam logic [31:0] KEY     = 32'hB119_24E1;
  localparam logic [31:0] OP_ERS  = 32'h3141_5927;
  localparam logic [31:0] OP_PRG  = 32'h2718_2818;
  localparam logic [31:0] OP_RD   = 32'h1602_1765;

  localparam logic [RA_W-1:0] A_KEY   = RA_W'(0);
  localparam logic [RA_W-1:0] A_CTL0  = RA_W'(1);
  localparam logic [RA_W-1:0] A_CTL1  = RA_W'(2);
  localparam logic [RA_W-1:0] A_TRANS = RA_W'(3);
  localparam logic [RA_W-1:0] A_ERR   = RA_W'(4);
  localparam logic [RA_W-1:0] A_DOUT  = RA_W'(5);

  logic [31:0]      mem  [2][BANK_W];
  logic [31:0]      info [INFO_WORDS];
  logic [31:0]      wbuf [BUF_WORDS];

  logic [OFF_W-1:0] t_off;
  logic             t_info;
  logic [SZW-1:0]   t_size;
  logic             armed;
  logic [2:0]       err;
  logic [31:0]      dout;

  logic [1:0]       busy;
  logic [31:0]      op_q  [2];
  logic [AW-1:0]    off_q [2];
  logic             info_q[2];
  logic [SZW-1:0]   sz_q  [2];
  logic [CNT_W-1:0] cnt   [2];
  logic [AW-1:0]    pbase [2];

  wire       ctl_wr  = reg_wr && (reg_addr == A_CTL0 || reg_addr == A_CTL1);
  wire       sel     = (reg_addr == A_CTL1);
  wire       known   = (reg_wdata == OP_ERS) || (reg_wdata == OP_PRG) || (reg_wdata == OP_RD);
  wire       bad_op  = !known || (reg_wdata == OP_ERS && t_info) || (reg_wdata == OP_RD && !t_info);
  wire       row_bad = ({1'b0, t_off[RL-1:0]} + (RL+1)'(t_size)) >= (RL+1)'(ROW_W);
  wire       e_busy  = ctl_wr && busy[sel];
  wire       e_bad   = ctl_wr && !busy[sel] && armed && bad_op;
  wire       e_row   = ctl_wr && !busy[sel] && armed && !bad_op && reg_wdata == OP_PRG && row_bad;
  wire       start   = ctl_wr && !busy[sel] && armed && !bad_op && !(reg_wdata == OP_PRG && row_bad);
  wire       err_rd  = reg_rd && reg_addr == A_ERR;

  logic [CNT_W-1:0] t_load;
  always_comb begin
    if (reg_wdata == OP_ERS)      t_load = CNT_W'(T_ERASE - 1);
    else if (reg_wdata == OP_PRG) t_load = CNT_W'(T_PROG - 1);
    else                          t_load = CNT_W'(T_READ - 1);
  end

  always_comb
    for (int b = 0; b < 2; b++)
      pbase[b] = (off_q[b] >> PLOG) << PLOG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        for (int i = 0; i < BANK_W; i++) mem[b][i] <= '1;
        op_q[b]   <= '0;
        off_q[b]  <= '0;
        info_q[b] <= 1'b0;
        sz_q[b]   <= '0;
        cnt[b]    <= '0;
      end
      for (int i = 0; i < INFO_WORDS; i++) info[i] <= '1;
      for (int i = 0; i < BUF_WORDS; i++)  wbuf[i] <= '0;
      busy   <= '0;
      t_off  <= '0;
      t_info <= 1'b0;
      t_size <= '0;
      armed  <= 1'b0;
      err    <= '0;
      dout   <= '0;
    end else begin
      err <= (err_rd ? 3'b000 : err) | {e_bad, e_busy, e_row};

      if (reg_wr && reg_addr == A_KEY) armed <= (reg_wdata == KEY);
      else if (ctl_wr)                 armed <= 1'b0;

      if (reg_wr && reg_addr == A_TRANS) begin
        t_off  <= reg_wdata[OFF_W-1:0];
        t_info <= reg_wdata[OFF_W];
        t_size <= reg_wdata[OFF_W+1 +: SZW];
      end
      if (reg_wr && reg_addr[RA_W-1]) wbuf[reg_addr[SZW-1:0]] <= reg_wdata;

      if (start) begin
        busy[sel]   <= 1'b1;
        op_q[sel]   <= reg_wdata;
        off_q[sel]  <= t_off[AW-1:0];
        info_q[sel] <= t_info;
        sz_q[sel]   <= t_size;
        cnt[sel]    <= t_load;
      end

      for (int b = 0; b < 2; b++) begin
        if (busy[b]) begin
          if (cnt[b] != '0) cnt[b] <= cnt[b] - 1'b1;
          else begin
            busy[b] <= 1'b0;
            if (op_q[b] == OP_ERS) begin
              for (int i = 0; i < PAGE_W; i++) mem[b][pbase[b] + AW'(i)] <= '1;
            end else if (op_q[b] == OP_PRG) begin
              for (int i = 0; i < BUF_WORDS; i++)
                if (SZW'(i) <= sz_q[b]) begin
                  if (info_q[b])
                    info[off_q[b][IW-1:0] + IW'(i)] <= info[off_q[b][IW-1:0] + IW'(i)] & wbuf[i];
                  else
                    mem[b][off_q[b] + AW'(i)] <= mem[b][off_q[b] + AW'(i)] & wbuf[i];
                end
            end else begin
              dout <= info[off_q[b][IW-1:0]];
            end
          end
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[RA_W-1]) reg_rdata = wbuf[reg_addr[SZW-1:0]];
    else case (reg_addr)
      A_CTL0:  reg_rdata = busy[0] ? op_q[0] : '0;
      A_CTL1:  reg_rdata = busy[1] ? op_q[1] : '0;
      A_TRANS: reg_rdata = 32'({t_size, t_info, t_off});
      A_ERR:   reg_rdata = {29'b0, err};
      A_DOUT:  reg_rdata = dout;
      default: reg_rdata = '0;
    endcase
  end

  assign rd_ready = !(rd_req && busy[rd_bank]);
  assign rd_data  = mem[rd_bank][rd_addr];
endmodule

// File: rtl/flash_pe_ctrl_chk.sv
module flash_pe_ctrl_chk #(
  parameter int RA_W  = 6,
  parameter int AW    = 10,
  parameter int SZ_W  = 5,
  parameter int ROW_W = 64,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [RA_W-1:0]  reg_addr,
  input logic             armed,
  input logic [1:0]       busy,
  input logic [2:0]       err,
  input logic [31:0]      op0,
  input logic [AW-1:0]    off0,
  input logic [SZ_W-1:0]  sz0,
  input logic [CNT_W-1:0] cnt0
);
  localparam int RL = $clog2(ROW_W);

  p_start_from_ctl0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy[0]) |-> $past(reg_wr && reg_addr == RA_W'(1)));

  p_start_from_ctl1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy[1]) |-> $past(reg_wr && reg_addr == RA_W'(2)));

  p_key_single_use_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == RA_W'(1) || reg_addr == RA_W'(2))) |=> !armed);

  p_unkeyed_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_W'(1) && !armed && !busy[0]) |=> !busy[0]);

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy[0] && cnt0 != '0) |=> busy[0]);

  p_row_fit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy[0] && op0 == 32'h2718_2818) |->
      (({1'b0, off0[RL-1:0]} + (RL+1)'(sz0)) < (RL+1)'(ROW_W)));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_addr == RA_W'(4)) |=> ((err & $past(err)) == $past(err)));
endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk #(
  .RA_W(RA_W), .AW(AW), .SZ_W(SZW), .ROW_W(ROW_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .armed(armed), .busy(busy), .err(err), .op0(op_q[0]), .off0(off_q[0]),
  .sz0(sz_q[0]), .cnt0(cnt[0])
);

// File: tb/flash_pe_ctrl_bench.sv
`timescale 1ns/100ps
module flash_pe_ctrl_bench;
  localparam int TE = 20, TP = 6, TR = 3;
  localparam logic [31:0] KEY = 32'hB119_24E1, ERS = 32'h3141_5927,
                          PRG = 32'h2718_2818, RDO = 32'h1602_1765;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, rd_req = 0, rd_bank = 0;
  logic [5:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, rd_data;
  logic [9:0] rd_addr = 0;
  logic rd_ready;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { string tag; logic [32:0] exp; logic [32:0] mask; bit port; } item_t;
  item_t q[$];
  item_t it;
  logic [32:0] got;

  flash_pe_ctrl u_flash_pe_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_req(rd_req), .rd_bank(rd_bank),
    .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data));

  always #2.5 clk = ~clk;

  always @(negedge clk) if (reg_rd || rd_req) begin
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL scoreboard: read with no expected item");
    end else begin
      it = q.pop_front();
      got = it.port ? {rd_ready, rd_data} : {1'b1, reg_rdata};
      if ((got & it.mask) != (it.exp & it.mask)) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.tag, got & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1; reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    q.push_back('{tag, {1'b1, e}, {33{1'b1}}, 1'b0});
    reg_rd = 1; reg_addr = a;
    @(posedge clk); #1; reg_rd = 0;
  endtask

  task automatic prd(input logic b, input logic [9:0] a, input logic rdy,
                     input logic [31:0] e, input string tag);
    q.push_back('{tag, {rdy, e}, rdy ? {33{1'b1}} : {1'b1, 32'b0}, 1'b1});
    rd_req = 1; rd_bank = b; rd_addr = a;
    @(posedge clk); #1; rd_req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic trans(input int off, input logic inf, input int sz);
    wr(6'd3, {10'b0, 5'(sz), inf, 16'(off)});
  endtask

  task automatic launch(input logic b, input logic [31:0] code);
    wr(6'd0, KEY);
    wr(b ? 6'd2 : 6'd1, code);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset state
    rd(6'd1, 0, "R1 ctrl0 reset");
    rd(6'd2, 0, "R1 ctrl1 reset");
    rd(6'd4, 0, "R1 err reset");
    prd(0, 10'd5, 1, ONES, "R1 array erased");
    // R3 no key, wrong key
    wr(6'd1, PRG);
    rd(6'd1, 0, "R3 unkeyed ignored");
    wr(6'd0, 32'h0000_1234);
    wr(6'd1, PRG);
    rd(6'd1, 0, "R3 wrong key ignored");
    rd(6'd4, 0, "R3 no error");
    // R5 / R4 program 4 words at offset 8
    wr(6'd32, 32'h1234_5678); wr(6'd33, 32'h9ABC_DEF0);
    wr(6'd34, 32'h0F0F_0F0F); wr(6'd35, 32'h0000_0000);
    trans(8, 0, 3);
    launch(0, PRG);
    for (int i = 0; i < TP; i++) rd(6'd1, PRG, "R4 ctrl0 busy window");
    rd(6'd1, 0, "R4 ctrl0 cleared after T_PROG");
    prd(0, 10'd8,  1, 32'h1234_5678, "R5 word 0");
    prd(0, 10'd9,  1, 32'h9ABC_DEF0, "R5 word 1");
    prd(0, 10'd10, 1, 32'h0F0F_0F0F, "R5 word 2");
    prd(0, 10'd11, 1, 32'h0000_0000, "R5 word 3");
    prd(0, 10'd12, 1, ONES, "R5 word past count");
    // R2 key consumed
    wr(6'd1, PRG);
    rd(6'd1, 0, "R2 key consumed");
    // R5 AND semantics
    wr(6'd32, 32'hFF00_FF00);
    trans(8, 0, 0);
    launch(0, PRG);
    idle(TP);
    prd(0, 10'd8, 1, 32'h1200_5600, "R5 program ANDs");
    // R6 row crossing
    trans(60, 0, 7);
    launch(0, PRG);
    rd(6'd1, 0, "R6 row cross not started");
    rd(6'd4, 32'd1, "R6 row error bit");
    rd(6'd4, 0, "R11 error cleared by read");
    prd(0, 10'd60, 1, ONES, "R6 no word changed");
    trans(56, 0, 7);
    launch(0, PRG);
    rd(6'd1, PRG, "R6 row end accepted");
    idle(TP);
    rd(6'd4, 0, "R6 no error on fit");
    // R7 / R9 / R10 erase on bank 1
    wr(6'd32, 32'h0);
    trans(100, 0, 0); launch(1, PRG); idle(TP);
    trans(520, 0, 0); launch(1, PRG); idle(TP);
    prd(1, 10'd520, 1, 32'h0, "R5 bank1 programmed");
    trans(600, 0, 0);
    launch(1, ERS);
    prd(1, 10'd520, 0, 0, "R9 busy bank stalled");
    prd(0, 10'd8, 1, 32'h1200_5600, "R9 other bank served");
    wr(6'd2, PRG);
    rd(6'd4, 32'd2, "R10 busy violation bit");
    rd(6'd2, ERS, "R10 running code kept");
    idle(TE - 5);
    rd(6'd2, 0, "R10 completion cycle unchanged");
    prd(1, 10'd520, 1, ONES, "R7 page erased");
    prd(1, 10'd100, 1, 32'h0, "R7 other page kept");
    // R8 info program and read
    wr(6'd32, 32'hA5A5_F00F);
    trans(5, 1, 0); launch(1, PRG); idle(TP);
    launch(1, RDO); idle(TR);
    rd(6'd5, 32'hA5A5_F00F, "R8 info read data");
    // R12 illegal requests
    launch(0, ERS);
    rd(6'd1, 0, "R12 info erase not started");
    rd(6'd4, 32'd4, "R12 info erase bad op");
    trans(5, 0, 0);
    launch(0, RDO);
    rd(6'd4, 32'd4, "R12 main info-read bad op");
    // R11 accumulate
    trans(60, 0, 7); launch(0, PRG);
    launch(0, 32'hDEAD_BEEF);
    rd(6'd1, 0, "R12 unknown code not started");
    rd(6'd4, 32'd5, "R11 bits accumulate");
    rd(6'd4, 0, "R11 cleared");
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule